// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the command front end of a NOR-style flash model. The host issues bus write cycles on a level write strobe: the address is taken when the strobe is raised and the data when it drops. A sequence machine reads these cycles as unlock codes and commands. It runs in one of three read modes: plain array reads, identifier reads, or status reads while an internal operation is running.

The internal array is small. Each word sits at word `addr[SECT_AW-1:0]` of sector `addr[ADDR_W-1 -: SECT_W]`. Every word powers up erased to all ones. A program operation can only clear bits, and it is refused for sectors flagged in `PROT_MASK`. The sector erase sequence starts a timed busy period that can be suspended and resumed. The erase does not change the array; it is modelled only far enough to gate the suspend and resume commands.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode. Every word reads 16'hFFFF with no command written, and busy_o and susp_o are low.
- R2: A write cycle takes its address from addr_i in the cycle where we_i first reads high. It takes its data from wdata_i in the cycle where we_i first reads low again, and the command acts at that edge. addr_i and wdata_i values at any other time have no effect.
- R3: The program sequence is 16'hAA at 11'h555, then 16'h55 at 11'h2AA, then 16'hA0 at 11'h555, then the target address and data. The block then holds busy_o high for PROG_CYCLES clocks, after which the target word becomes old AND data.
- R4: While a program is busy, every read returns a status word. In that word bit 7 is the inverse of bit 7 of the data being programmed and all other bits are 0. Writes made during the busy period have no effect.
- R5: A program aimed at a protected sector (PROT_MASK bit of the sector set, default sector 2) never raises busy_o and leaves the word unchanged.
- R6: A write whose address or data breaks the expected sequence drops the partial sequence and leaves identifier mode, returning to array reads.
- R7: After 16'hAA at 11'h555, 16'h55 at 11'h2AA and 16'h90 at 11'h555, reads decode addr_i[7:0] as follows: 8'h00 gives 16'h0004, 8'h01 gives 16'h2227, 8'h02 gives the protect bit of sector addr_i[10:9] in bit 0, and any other offset gives 0.
- R8: Identifier mode ends on either reset form: a single write of 16'hF0 at any address, or the two unlock cycles followed by 16'hF0 at 11'h555.
- R9: The erase sequence is 16'hAA at 11'h555, 16'h55 at 11'h2AA, 16'h80 at 11'h555, 16'hAA at 11'h555, 16'h55 at 11'h2AA, then 16'h30 at any address. It keeps busy_o high for ERASE_CYCLES unsuspended clocks. While it runs, reads return 16'h0008. The array is left unchanged.
- R10: While an erase runs, 16'hB0 suspends it: susp_o rises, busy_o falls, and reads return array data. 16'h30 resumes it. Every other write during the erase, suspended or not, has no effect.
- R11: Outside an erase, writes of 16'hB0 or 16'h30 are ignored: identifier mode stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, held high for one bus write |
| addr_i | input | ADDR_W | Word address for reads and writes |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (array, identifier or status) |
| busy_o | output | 1 | Program or unsuspended erase in progress |
| susp_o | output | 1 | Erase suspended |

## Verification
The assertions assume the host never holds we_i high across a reset and that each strobe lasts at least one clock. Under that assumption every strobe fall produces exactly one command event. The bench drives every write as one high clock followed by one low clock. Inside each write it inverts addr_i and wdata_i during the cycles that should be ignored, which tests the capture points on every cycle. It waits on busy_o before it starts a new operation, except where a requirement needs writes issued during the busy period.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UL1, SQ_UL2, SQ_PGM, SQ_ER1, SQ_ER2, SQ_ER3
  } seq_e;

  localparam logic [7:0]  CMD_UL1  = 8'hAA;
  localparam logic [7:0]  CMD_UL2  = 8'h55;
  localparam logic [7:0]  CMD_PGM  = 8'hA0;
  localparam logic [7:0]  CMD_ID   = 8'h90;
  localparam logic [7:0]  CMD_RST  = 8'hF0;
  localparam logic [7:0]  CMD_ERS  = 8'h80;
  localparam logic [7:0]  CMD_SUSP = 8'hB0;
  localparam logic [7:0]  CMD_RES  = 8'h30;

  localparam logic [10:0] UL_ADDR1 = 11'h555;
  localparam logic [10:0] UL_ADDR2 = 11'h2AA;

  localparam logic [15:0] MFR_ID     = 16'h0004;
  localparam logic [15:0] DEV_ID     = 16'h2227;
  localparam logic [15:0] ERS_STATUS = 16'h0008;
endpackage

// File: rtl/fc_wr_capture.sv
module fc_wr_capture #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  logic              we_q;
  logic [ADDR_W-1:0] addr_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q       <= 1'b0;
      addr_lat_q <= '0;
    end else begin
      we_q <= we_i;
      if (we_i && !we_q) addr_lat_q <= addr_i;
    end
  end

  // data taken on the strobe's falling cycle
  assign cmd_valid_o = we_q && !we_i;
  assign cmd_addr_o  = addr_lat_q;
  assign cmd_data_o  = wdata_i;

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && we_i) |=> $stable(addr_lat_q));
endmodule

// File: rtl/fc_array.sv
module fc_array #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= mem_q[wr_idx_i] & wr_data_i;  // bits only clear
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/fc_seq.sv
module fc_seq
  import flash_pkg::*;
#(
  parameter int              ADDR_W       = 11,
  parameter int              DATA_W       = 16,
  parameter int              SECT_W       = 2,
  parameter int              SECT_AW      = 4,
  parameter int              PROG_CYCLES  = 16,
  parameter int              ERASE_CYCLES = 20,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 4'b0100,
  localparam int             IDX_W        = SECT_W + SECT_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              autosel_o,
  output logic              prog_busy_o,
  output logic              prog_commit_o,
  output logic [IDX_W-1:0]  prog_idx_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              erase_run_o,
  output logic              erase_susp_o
);
  localparam int PCW = $clog2(PROG_CYCLES + 1);
  localparam int ECW = $clog2(ERASE_CYCLES + 1);

  seq_e              seq_q;
  logic              autosel_q, prog_busy_q, erase_q, susp_q;
  logic [PCW-1:0]    prog_cnt_q;
  logic [ECW-1:0]    erase_cnt_q;
  logic [IDX_W-1:0]  prog_idx_q;
  logic [SECT_W-1:0] prog_sect_q;
  logic [DATA_W-1:0] prog_data_q;

  logic [SECT_W-1:0] cmd_sect;
  logic [7:0]        code;
  logic              at1, at2, is_ul1, is_ul2, is_susp, is_res, prot_hit;

  assign cmd_sect = cmd_addr_i[ADDR_W-1 -: SECT_W];
  assign code     = cmd_data_i[7:0];
  assign at1      = (cmd_addr_i[10:0] == UL_ADDR1);
  assign at2      = (cmd_addr_i[10:0] == UL_ADDR2);
  assign is_ul1   = at1 && (code == CMD_UL1);
  assign is_ul2   = at2 && (code == CMD_UL2);
  assign is_susp  = (code == CMD_SUSP);
  assign is_res   = (code == CMD_RES);
  assign prot_hit = PROT_MASK[cmd_sect];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q       <= SQ_IDLE;
      autosel_q   <= 1'b0;
      prog_busy_q <= 1'b0;
      prog_cnt_q  <= '0;
      prog_idx_q  <= '0;
      prog_sect_q <= '0;
      prog_data_q <= '0;
      erase_q     <= 1'b0;
      susp_q      <= 1'b0;
      erase_cnt_q <= '0;
    end else if (prog_busy_q) begin
      prog_cnt_q <= prog_cnt_q - PCW'(1);
      if (prog_cnt_q == PCW'(1)) prog_busy_q <= 1'b0;
    end else if (erase_q) begin
      if (!susp_q) begin
        erase_cnt_q <= erase_cnt_q - ECW'(1);
        if (erase_cnt_q == ECW'(1)) erase_q <= 1'b0;
      end
      if (cmd_valid_i) begin
        if (!susp_q && is_susp && erase_cnt_q != ECW'(1)) susp_q <= 1'b1;
        else if (susp_q && is_res)                        susp_q <= 1'b0;
      end
    end else if (cmd_valid_i) begin
      seq_q <= SQ_IDLE;
      unique case (seq_q)
        SQ_IDLE: begin
          if (is_ul1)                     seq_q     <= SQ_UL1;
          else if (!(is_susp || is_res))  autosel_q <= 1'b0;  // F0 or wrong cycle
        end
        SQ_UL1: if (is_ul2) seq_q <= SQ_UL2; else autosel_q <= 1'b0;
        SQ_UL2: begin
          if (at1 && code == CMD_PGM)      seq_q     <= SQ_PGM;
          else if (at1 && code == CMD_ID)  autosel_q <= 1'b1;
          else if (at1 && code == CMD_ERS) seq_q     <= SQ_ER1;
          else                             autosel_q <= 1'b0;
        end
        SQ_PGM: begin
          autosel_q <= 1'b0;
          if (!prot_hit) begin
            prog_busy_q <= 1'b1;
            prog_cnt_q  <= PCW'(PROG_CYCLES);
            prog_idx_q  <= {cmd_sect, cmd_addr_i[SECT_AW-1:0]};
            prog_sect_q <= cmd_sect;
            prog_data_q <= cmd_data_i;
          end
        end
        SQ_ER1: if (is_ul1) seq_q <= SQ_ER2; else autosel_q <= 1'b0;
        SQ_ER2: if (is_ul2) seq_q <= SQ_ER3; else autosel_q <= 1'b0;
        SQ_ER3: begin
          autosel_q <= 1'b0;
          if (is_res) begin
            erase_q     <= 1'b1;
            erase_cnt_q <= ECW'(ERASE_CYCLES);
          end
        end
        default: autosel_q <= 1'b0;
      endcase
    end
  end

  assign autosel_o     = autosel_q;
  assign prog_busy_o   = prog_busy_q;
  assign prog_commit_o = prog_busy_q && (prog_cnt_q == PCW'(1));
  assign prog_idx_o    = prog_idx_q;
  assign prog_data_o   = prog_data_q;
  assign erase_run_o   = erase_q;
  assign erase_susp_o  = susp_q;

  // R5
  prot_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_busy_q |-> !PROT_MASK[prog_sect_q]);
  // R3
  prog_cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_busy_q |-> (prog_cnt_q != '0));
  // R2
  prog_start_on_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_busy_q) |-> $past(cmd_valid_i));
  // R10
  susp_in_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_q |-> erase_q);
  // R11
  susp_needs_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_q) |-> $past(erase_q));
  // R7
  id_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(autosel_q && (prog_busy_q || erase_q)));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 16,
  parameter int SECT_W       = 2,
  parameter int SECT_AW      = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 20,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              susp_o
);
  localparam int IDX_W = SECT_W + SECT_AW;

  logic              cmd_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              autosel, prog_busy, prog_commit, erase_run, erase_susp;
  logic [IDX_W-1:0]  prog_idx, rd_idx;
  logic [DATA_W-1:0] prog_data, arr_rd, status_w;
  logic [SECT_W-1:0] rd_sect;

  fc_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .cmd_valid_o(cmd_valid), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  fc_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .SECT_AW(SECT_AW),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .PROT_MASK(PROT_MASK)
  ) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .autosel_o(autosel), .prog_busy_o(prog_busy), .prog_commit_o(prog_commit),
    .prog_idx_o(prog_idx), .prog_data_o(prog_data),
    .erase_run_o(erase_run), .erase_susp_o(erase_susp)
  );

  assign rd_sect = addr_i[ADDR_W-1 -: SECT_W];
  assign rd_idx  = {rd_sect, addr_i[SECT_AW-1:0]};

  fc_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_arr (
    .clk_i, .rst_ni,
    .wr_en_i(prog_commit), .wr_idx_i(prog_idx), .wr_data_i(prog_data),
    .rd_idx_i(rd_idx), .rd_data_o(arr_rd)
  );

  always_comb begin
    status_w    = '0;
    status_w[7] = ~prog_data[7];
  end

  always_comb begin
    if (prog_busy)                    rdata_o = status_w;
    else if (erase_run && !erase_susp) rdata_o = DATA_W'(ERS_STATUS);
    else if (autosel) begin
      unique case (addr_i[7:0])
        8'h00:   rdata_o = DATA_W'(MFR_ID);
        8'h01:   rdata_o = DATA_W'(DEV_ID);
        8'h02:   rdata_o = DATA_W'(PROT_MASK[rd_sect]);
        default: rdata_o = '0;
      endcase
    end else                           rdata_o = arr_rd;
  end

  assign busy_o = prog_busy || (erase_run && !erase_susp);
  assign susp_o = erase_susp;

  // R4
  busy_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_busy && erase_run));
  // R10
  susp_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> !busy_o);
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_i = 1'b0;
  logic [10:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        busy_o, susp_o;

  int errors = 0;
  int checks = 0;
  int busy_cnt = 0;
  logic cnt_en = 1'b0;
  logic [15:0] exp_mem [64];

  always #10 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o), .susp_o(susp_o)
  );

  always @(negedge clk) if (cnt_en && busy_o) busy_cnt++;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk); addr_i = a; wdata_i = ~d; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0; wdata_i = d; addr_i = ~a;
    @(negedge clk); wdata_i = ~d;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    addr_i = a; #2; d = rdata_o;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
  endtask

  function automatic logic [10:0] wa(input int s, input int w);
    return 11'((s << 9) | w);
  endfunction

  task automatic prog(input logic [10:0] a, input logic [15:0] d, input logic chk_stat);
    logic [15:0] r;
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0);
    wr(a, d);
    if (chk_stat) begin
      rd(a, r);
      chk("R4 status", r, {8'h00, ~d[7], 7'h00});
    end
  endtask

  task automatic idmode();
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0090);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] r, d;
    int s, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {15'h0, busy_o}, 16'h0);
    chk("R1 susp", {15'h0, susp_o}, 16'h0);
    for (int i = 0; i < 64; i++) begin
      exp_mem[i] = 16'hFFFF;
      rd(wa(i >> 4, i & 15), r);
      chk("R1 erased", r, 16'hFFFF);
    end

    // R3 / R5 sweep every word, status on each
    for (int i = 0; i < 64; i++) begin
      s = i >> 4; w = i & 15;
      d = 16'hFFFF ^ (16'h1 << w) ^ 16'((s + 1) << 12);
      cnt_en = 1'b1; busy_cnt = 0;
      prog(wa(s, w), d, s != 2);
      wait_idle();
      cnt_en = 1'b0;
      if (s == 2) chk("R5 no busy", 16'(busy_cnt), 16'd0);
      else begin
        chk("R3 busy len", 16'(busy_cnt), 16'd16);
        exp_mem[i] = exp_mem[i] & d;
      end
    end
    for (int i = 0; i < 64; i++) begin
      rd(wa(i >> 4, i & 15), r);
      chk(((i >> 4) == 2) ? "R5 protected" : "R3 word", r, exp_mem[i]);
    end
    // R3 second pass: AND behaviour
    for (int j = 0; j < 16; j++) begin
      d = 16'h5A5A ^ 16'(j * 257);
      prog(wa(1, j), d, 1'b0);
      wait_idle();
      exp_mem[16 + j] = exp_mem[16 + j] & d;
      rd(wa(1, j), r);
      chk("R3 and", r, exp_mem[16 + j]);
    end

    // R2 address at strobe rise only (wr drives ~a at fall)
    prog(wa(3, 5), 16'h0F0F, 1'b0); wait_idle();
    exp_mem[53] = exp_mem[53] & 16'h0F0F;
    rd(wa(3, 5), r);          chk("R2 target", r, exp_mem[53]);
    rd(~wa(3, 5), r);         chk("R2 other", r, exp_mem[10]);

    // R4 writes during busy ignored
    prog(wa(0, 0), 16'hFFFF, 1'b1);
    idmode();
    wait_idle();
    rd(wa(0, 0), r);          chk("R4 ignored", r, exp_mem[0]);

    // R7 identifier reads
    idmode();
    rd(11'h000, r);           chk("R7 mfr", r, 16'h0004);
    rd(11'h001, r);           chk("R7 dev", r, 16'h2227);
    rd(11'h402, r);           chk("R7 prot s2", r, 16'h0001);
    rd(11'h002, r);           chk("R7 prot s0", r, 16'h0000);
    rd(11'h605, r);           chk("R7 other", r, 16'h0000);
    rd(11'h200, r);           chk("R7 mfr s1", r, 16'h0004);
    // R11 suspend/resume ignored outside erase
    wr(11'h555, 16'h00B0);
    rd(11'h000, r);           chk("R11 after B0", r, 16'h0004);
    wr(11'h123, 16'h0030);
    rd(11'h001, r);           chk("R11 after 30", r, 16'h2227);
    chk("R11 susp", {15'h0, susp_o}, 16'h0);
    // R8 single-cycle reset
    wr(11'h123, 16'h00F0);
    rd(11'h000, r);           chk("R8 F0 short", r, exp_mem[0]);
    // R8 long reset
    idmode();
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00F0);
    rd(11'h001, r);           chk("R8 F0 long", r, exp_mem[1]);
    // R6 wrong cycle leaves id mode
    idmode();
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055);
    rd(11'h000, r);           chk("R6 id abort", r, exp_mem[0]);
    // R6 broken program sequence
    wr(11'h555, 16'h00AA); wr(11'h123, 16'h0055); wr(11'h555, 16'h00A0);
    wr(wa(0, 3), 16'h0000);
    chk("R6 no busy", {15'h0, busy_o}, 16'h0);
    rd(wa(0, 3), r);          chk("R6 unchanged", r, exp_mem[3]);

    // R9 / R10 erase with suspend
    cnt_en = 1'b1; busy_cnt = 0;
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(wa(1, 0), 16'h0030);
    rd(wa(1, 2), r);          chk("R9 status", r, 16'h0008);
    wr(11'h555, 16'h00B0);
    chk("R10 susp", {15'h0, susp_o}, 16'h1);
    chk("R10 busy low", {15'h0, busy_o}, 16'h0);
    rd(wa(1, 2), r);          chk("R10 array read", r, exp_mem[18]);
    wr(11'h123, 16'h00F0);
    repeat (30) @(negedge clk);
    chk("R10 ignored", {15'h0, susp_o}, 16'h1);
    wr(11'h000, 16'h0030);
    chk("R10 resume", {15'h0, susp_o}, 16'h0);
    wait_idle();
    cnt_en = 1'b0;
    chk("R9 length", 16'(busy_cnt), 16'd20);
    rd(wa(1, 0), r);          chk("R9 no change", r, exp_mem[16]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule